// File: doc/BRIEF.md
# Interrupt Acknowledge Response Sequencer

This block answers the processor's interrupt acknowledge pulses by placing response bytes on the data bus. It has two processor modes. With the mode input low, it serves an 8-bit processor and answers three acknowledge pulses. The first pulse gets a subroutine call opcode. The second gets the low byte of the service routine address. The third gets the high byte of that address. With the mode input high, it serves a 16-bit processor and returns a single vector number.

The low address byte combines programmed upper bits with the granted level. An interval input sets the spacing between service routines to either 4 or 8 bytes. The block latches the granted level when an acknowledge sequence begins, so a later change of level cannot alter bytes that are already in flight. Outside an active acknowledge strobe, the output enable is low and the data output reads zero.

Top module: `ack_vector_seq`

## Requirements
- R1: After reset, `bus_oe` is low. The next acknowledge pulse is handled as the first pulse of a sequence.
- R2: `bus_oe` is high only while `ack` is high. Whenever `bus_oe` is low, `bus_out` is 8'h00.
- R3: In 8-bit mode (`mode16`=0), the first acknowledge pulse drives 8'hCD with `bus_oe` high.
- R4: In 8-bit mode with `gap4`=1 (4-byte spacing), the second pulse drives `{base_lo[2:0], level[2:0], 2'b00}`.
- R5: In 8-bit mode with `gap4`=0 (8-byte spacing), the second pulse drives `{base_lo[2:1], level[2:0], 3'b000}`.
- R6: In 8-bit mode, the third pulse drives `base_hi`.
- R7: A sequence in 8-bit mode ends after its third pulse, and the next pulse starts a new sequence.
- R8: In 16-bit mode (`mode16`=1), the first pulse keeps `bus_oe` low. The second pulse drives `{base_hi[7:3], level[2:0]}`, and the pulse after it starts a new sequence.
- R9: The level used in a sequence is `grant_lvl` as sampled on the first clock edge of the first pulse. Later changes to `grant_lvl` have no effect until the next sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack | input | 1 | Acknowledge strobe, active high, one pulse per byte |
| grant_lvl | input | 3 | Level granted by the priority logic |
| mode16 | input | 1 | 0 selects 8-bit processor mode, 1 selects 16-bit processor mode |
| gap4 | input | 1 | 1 selects 4-byte routine spacing, 0 selects 8-byte spacing |
| base_lo | input | 3 | Programmed address bits A7..A5 |
| base_hi | input | 8 | Programmed high address byte; bits 7..3 also form the vector top |
| bus_out | output | 8 | Response byte |
| bus_oe | output | 1 | Drive enable for `bus_out` |

## Verification
The bench changes `grant_lvl` between pulses of a sequence. A design that read the level live instead of latching it would return a different low byte or vector. It switches between 4-byte and 8-byte spacing with all base bits set. A design with the wrong bit split would leak `base_lo[0]` or shift the level by one position. It runs back-to-back sequences in both modes. A wrong wrap count would return the call opcode in the middle of a sequence or an address byte where the call opcode belongs. It also checks that the first pulse in 16-bit mode leaves the bus undriven.

// File: rtl/ack_vector_seq.sv
module ack_vector_seq #(
  parameter logic [7:0] CALL_OP = 8'hCD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack,
  input  logic [2:0] grant_lvl,
  input  logic       mode16,
  input  logic       gap4,
  input  logic [2:0] base_lo,
  input  logic [7:0] base_hi,
  output logic [7:0] bus_out,
  output logic       bus_oe
);

  logic       ack_q;
  logic [1:0] step_q;
  logic [2:0] lvl_q;
  logic [7:0] resp;

  wire ack_rise = ack & ~ack_q;
  wire ack_fall = ~ack & ack_q;
  wire last     = mode16 ? (step_q != 2'd0) : (step_q == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      step_q <= 2'd0;
      lvl_q  <= 3'd0;
    end else begin
      ack_q <= ack;
      if (ack_rise && step_q == 2'd0) lvl_q <= grant_lvl;
      if (ack_fall) step_q <= last ? 2'd0 : step_q + 2'd1;
    end
  end

  always_comb begin
    case (step_q)
      2'd0:    resp = CALL_OP;
      2'd1:    resp = mode16 ? {base_hi[7:3], lvl_q}
                     : gap4  ? {base_lo, lvl_q, 2'b00}
                             : {base_lo[2:1], lvl_q, 3'b000};
      default: resp = base_hi;
    endcase
  end

  assign bus_oe  = ack & ~(mode16 & (step_q == 2'd0));
  assign bus_out = bus_oe ? resp : 8'h00;

  assert_step_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_q != 2'd3);

  assert_step_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> $stable(step_q));

  assert_lvl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != 2'd0) |=> $stable(lvl_q));

  assert_wide_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && mode16 && step_q == 2'd1) |=> (step_q == 2'd0));

  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (!bus_oe && bus_out == 8'h00));

endmodule

// File: tb/ack_vector_seq_test.sv
module ack_vector_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack = 1'b0;
  logic [2:0] grant_lvl = 3'd0;
  logic       mode16 = 1'b0;
  logic       gap4 = 1'b1;
  logic [2:0] base_lo = 3'd0;
  logic [7:0] base_hi = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;

  int total = 0;
  int bad = 0;
  int seed = 1234;

  always #5 clk = ~clk;

  ack_vector_seq uut (
    .clk(clk), .rst_n(rst_n), .ack(ack), .grant_lvl(grant_lvl),
    .mode16(mode16), .gap4(gap4), .base_lo(base_lo), .base_hi(base_hi),
    .bus_out(bus_out), .bus_oe(bus_oe));

  function automatic logic [8:0] expect_byte(input logic m16, input logic g4,
      input logic [2:0] lo, input logic [7:0] hi, input logic [2:0] lv, input int idx);
    if (m16) return (idx == 0) ? 9'h000 : {1'b1, hi[7:3], lv};
    case (idx)
      0: return {1'b1, 8'hCD};
      1: return g4 ? {1'b1, lo, lv, 2'b00} : {1'b1, lo[2:1], lv, 3'b000};
      default: return {1'b1, hi};
    endcase
  endfunction

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got oe=%b data=%02h expected oe=%b data=%02h",
               req, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic pulse(output logic [8:0] seen);
    @(negedge clk) ack = 1'b1;
    @(posedge clk);
    #2 seen = {bus_oe, bus_out};
    @(negedge clk) ack = 1'b0;
    @(posedge clk);
    #2 check("R2", {bus_oe, bus_out}, 9'h000);
    @(posedge clk);
  endtask

  task automatic run_seq(input logic m16, input logic g4, input logic [2:0] lo,
      input logic [7:0] hi, input logic [2:0] lv, input logic disturb, input string req);
    logic [8:0] seen;
    int n;
    n = m16 ? 2 : 3;
    @(negedge clk);
    mode16 = m16; gap4 = g4; base_lo = lo; base_hi = hi; grant_lvl = lv;
    for (int i = 0; i < n; i++) begin
      pulse(seen);
      check(req, seen, expect_byte(m16, g4, lo, hi, lv, i));
      if (disturb) grant_lvl = ~lv;
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #2 check("R1", {bus_oe, bus_out}, 9'h000);
        @(negedge clk) rst_n = 1'b1;
        run_seq(0, 1, 3'b101, 8'h3C, 3'd6, 0, "R3 R4 R6");
        run_seq(0, 1, 3'b111, 8'hFF, 3'd0, 0, "R4 R7");
        run_seq(0, 0, 3'b111, 8'h81, 3'd7, 0, "R5");
        run_seq(0, 0, 3'b110, 8'h12, 3'd5, 1, "R5 R9");
        run_seq(1, 0, 3'b000, 8'hA5, 3'd3, 0, "R8");
        run_seq(1, 1, 3'b111, 8'hF8, 3'd7, 1, "R8 R9");
        run_seq(0, 1, 3'b010, 8'h44, 3'd1, 1, "R7 R9");
        for (int k = 0; k < 200; k++) begin
          logic [31:0] r;
          r = $urandom(seed + k);
          run_seq(r[0], r[1], r[4:2], r[12:5], r[15:13], r[16], "R3 R4 R5 R6 R8 R9");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_any
  end
endmodule